// File: doc/BRIEF.md
# Capture/Compare Timer with Flag-Driven Interrupt

This block is a free-running counter with three dedicated input-capture channels, four dedicated output-compare channels and one channel that a mode bit turns into either a fourth capture or a fifth compare. A capture channel copies the counter into its own register when its input shows the edge chosen by a 2-bit code. A compare channel raises its flag whenever the counter reaches the value software wrote into it.

Each of the eight channels owns one status flag and one interrupt-enable bit. These sit in two 8-bit registers that use the same bit layout. Software clears a flag by writing a one to its position. A single interrupt line stays high for as long as any flag and its enable bit are both set.

A plain synchronous write port and a combinational read port reach every register. Pin actions on compare, counter prescaling and pulse accumulation are not part of this block.

Top module: `capcmp_timer`

## Requirements
- R1: The counter resets to 0, increases by one on every clock, wraps from all ones to 0, and can be read at address 4.
- R2: Each capture channel has a 2-bit edge code with the high bit B and the low bit A. The code values are: 00 captures nothing, 01 captures on rising edges only, 10 captures on falling edges only, 11 captures on both edges. In the edge register at address 0, bits [7:6] are the shared channel, [5:4] capture 1, [3:2] capture 2 and [1:0] capture 3.
- R3: Capture inputs pass through a two-stage synchronizer. On a selected edge, the capture register is loaded with the counter value and the flag is set in the same cycle. The captured value equals the counter value read in the cycle just before the input changed, plus 2. Capture registers 1 to 3 are read at addresses 8 to 10.
- R4: A compare flag is set at the clock edge that ends the cycle in which the counter equals that channel's compare value. Compare registers 1 to 4 are read and written at addresses 12 to 15, and they reset to all ones.
- R5: The flag register (address 2) and the mask register (address 1) share one layout. Bit 7 is compare 1, bit 6 compare 2, bit 5 compare 3, bit 4 compare 4, bit 3 the shared channel, bit 2 capture 1, bit 1 capture 2 and bit 0 capture 3.
- R6: Writing a one to a flag bit clears it. Writing zero leaves the flag unchanged.
- R7: When a hardware set and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R8: `irq` is high exactly while some flag bit and the mask bit at the same position are both one.
- R9: Bit 0 of address 3 selects the shared channel's function. With 1 it captures on `cap_in[3]` under the field at [7:6] and loads the register at address 11. With 0 it compares the counter against the register at address 11, which is writable. In either mode, the function that is not selected never sets flag bit 3.
- R10: After reset the edge, mask, flag and mode registers read 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr`, combinational |
| cap_in | input | 4 | Capture inputs: bits 0 to 2 are captures 1 to 3, bit 3 is the shared channel |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the timer with `CNT_W` = 8 and the default two-stage synchronizer. With this setting the counter wraps every 256 cycles, so the wrap from all ones to zero is checked directly within a short run. All register fields keep their full 8-bit layout at this width. Because the synchronizer depth is fixed, the capture latency is a known constant, so the bench can predict each captured counter value exactly. It can also hit the single cycle in which a compare set and a clearing write coincide.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
   localparam int ADDR_W  = 4;
   localparam int FLAG_W  = 8;
   localparam int NUM_IC  = 3;
   localparam int NUM_OC  = 4;
   localparam int NUM_EDG = NUM_IC + 1;

   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;

   localparam logic [ADDR_W-1:0] A_EDGE   = 4'd0;
   localparam logic [ADDR_W-1:0] A_MASK   = 4'd1;
   localparam logic [ADDR_W-1:0] A_FLAG   = 4'd2;
   localparam logic [ADDR_W-1:0] A_MODE   = 4'd3;
   localparam logic [ADDR_W-1:0] A_CNT    = 4'd4;
   localparam logic [ADDR_W-1:0] A_CAP0   = 4'd8;
   localparam logic [ADDR_W-1:0] A_SHARED = 4'd11;
   localparam logic [ADDR_W-1:0] A_CMP0   = 4'd12;

   localparam int BIT_SHARED = 3;
endpackage

// File: rtl/capcmp_edge.sv
module capcmp_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_i,
   input  logic [1:0] code_i,
   output logic       det_o
);
   localparam int CHAIN_W = SYNC_STAGES + 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("capcmp_edge: SYNC_STAGES must be at least 2");
   end

   logic [CHAIN_W-1:0] chain_q;
   logic               lvl_now, lvl_old, rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[CHAIN_W-2:0], pin_i};
   end

   assign lvl_now = chain_q[SYNC_STAGES-1];
   assign lvl_old = chain_q[SYNC_STAGES];
   assign rise    = lvl_now & ~lvl_old;
   assign fall    = ~lvl_now & lvl_old;
   assign det_o   = (code_i[0] & rise) | (code_i[1] & fall);

   // R2
   rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (det_o && code_i == 2'b01) |-> (chain_q[SYNC_STAGES-1] && !chain_q[SYNC_STAGES]));
   // R2
   fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (det_o && code_i == 2'b10) |-> (!chain_q[SYNC_STAGES-1] && chain_q[SYNC_STAGES]));
endmodule

// File: rtl/capcmp_cmp.sv
module capcmp_cmp #(
   parameter int             CNT_W = 16,
   parameter logic [CNT_W-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] wdata_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic [CNT_W-1:0] val_o,
   output logic             hit_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    val_o <= RST_VAL;
      else if (wr_i) val_o <= wdata_i;
   end

   assign hit_o = (cnt_i == val_o);

   // R4
   cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(val_o));
endmodule

// File: rtl/capcmp_flags.sv
module capcmp_flags
   import capcmp_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FLAG_W-1:0] set_i,
   input  logic [FLAG_W-1:0] clr_i,
   input  logic [FLAG_W-1:0] mask_i,
   output logic [FLAG_W-1:0] flag_o,
   output logic              irq_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_o <= '0;
      else        flag_o <= (flag_o & ~clr_i) | set_i;
   end

   assign irq_o = |(flag_o & mask_i);

   // R7
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((flag_o & $past(set_i)) == $past(set_i)));
   // R6
   w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((flag_o & $past(clr_i & ~set_i)) == '0));
   // R6
   no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((flag_o & ~$past(flag_o) & ~$past(set_i)) == '0));
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
   import capcmp_pkg::*;
#(
   parameter int               CNT_W       = 16,
   parameter int               SYNC_STAGES = 2,
   parameter logic [CNT_W-1:0] CMP_RST     = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   input  logic [NUM_EDG-1:0] cap_in,
   output logic              irq
);
   if (CNT_W < FLAG_W) begin : g_bad_width
      $error("capcmp_timer: CNT_W must be at least 8");
   end

   logic [CNT_W-1:0]  cnt_q;
   logic [FLAG_W-1:0] edge_q, mask_q, flag_w, set_v, clr_v;
   logic              mode_q;
   logic [CNT_W-1:0]  shared_q;
   logic [CNT_W-1:0]  cap_q   [NUM_IC];
   logic [CNT_W-1:0]  cmp_val [NUM_OC];
   logic [NUM_OC-1:0] cmp_hit;
   logic [NUM_EDG-1:0] det;
   logic [1:0]        code_w  [NUM_EDG];
   logic              shared_hit;

   // free-running counter
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   // control registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_q <= '0;
         mask_q <= '0;
         mode_q <= 1'b0;
      end else if (bus_wr) begin
         if (bus_addr == A_EDGE) edge_q <= bus_wdata[FLAG_W-1:0];
         if (bus_addr == A_MASK) mask_q <= bus_wdata[FLAG_W-1:0];
         if (bus_addr == A_MODE) mode_q <= bus_wdata[0];
      end
   end

   // edge detectors: channels 0..2 dedicated, channel 3 shared
   for (genvar j = 0; j < NUM_EDG; j++) begin : g_edge
      if (j < NUM_IC) begin : g_ded
         assign code_w[j] = edge_q[(2*NUM_IC-1)-2*j -: 2];
      end else begin : g_shr
         assign code_w[j] = edge_q[2*NUM_EDG-1 -: 2];
      end
      capcmp_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
         .clk    (clk),
         .rst_n  (rst_n),
         .pin_i  (cap_in[j]),
         .code_i (code_w[j]),
         .det_o  (det[j])
      );
   end

   // dedicated capture registers
   for (genvar j = 0; j < NUM_IC; j++) begin : g_cap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cap_q[j] <= '0;
         else if (det[j]) cap_q[j] <= cnt_q;
      end
      assign set_v[NUM_IC-1-j] = det[j];

      // R3
      cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         det[j] |=> (cap_q[j] == $past(cnt_q) && flag_w[NUM_IC-1-j]));
   end

   // dedicated compare channels
   for (genvar i = 0; i < NUM_OC; i++) begin : g_cmp
      localparam logic [ADDR_W-1:0] MY_ADDR = A_CMP0 + ADDR_W'(i);
      capcmp_cmp #(.CNT_W(CNT_W), .RST_VAL(CMP_RST)) u_cmp (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_i    (bus_wr && bus_addr == MY_ADDR),
         .wdata_i (bus_wdata),
         .cnt_i   (cnt_q),
         .val_o   (cmp_val[i]),
         .hit_o   (cmp_hit[i])
      );
      assign set_v[FLAG_W-1-i] = cmp_hit[i];

      // R4
      cmp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_q == cmp_val[i]) |=> flag_w[FLAG_W-1-i]);
   end

   // shared channel: capture when mode_q = 1, compare when mode_q = 0
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               shared_q <= CMP_RST;
      else if (mode_q && det[NUM_EDG-1])        shared_q <= cnt_q;
      else if (bus_wr && bus_addr == A_SHARED)  shared_q <= bus_wdata;
   end

   assign shared_hit        = (cnt_q == shared_q);
   assign set_v[BIT_SHARED] = mode_q ? det[NUM_EDG-1] : shared_hit;
   assign clr_v = (bus_wr && bus_addr == A_FLAG) ? bus_wdata[FLAG_W-1:0] : '0;

   capcmp_flags u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_v),
      .clr_i  (clr_v),
      .mask_i (mask_q),
      .flag_o (flag_w),
      .irq_o  (irq)
   );

   // read mux
   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         A_EDGE:          bus_rdata[FLAG_W-1:0] = edge_q;
         A_MASK:          bus_rdata[FLAG_W-1:0] = mask_q;
         A_FLAG:          bus_rdata[FLAG_W-1:0] = flag_w;
         A_MODE:          bus_rdata[0]          = mode_q;
         A_CNT:           bus_rdata             = cnt_q;
         A_CAP0:          bus_rdata             = cap_q[0];
         A_CAP0 + 4'd1:   bus_rdata             = cap_q[1];
         A_CAP0 + 4'd2:   bus_rdata             = cap_q[2];
         A_SHARED:        bus_rdata             = shared_q;
         A_CMP0:          bus_rdata             = cmp_val[0];
         A_CMP0 + 4'd1:   bus_rdata             = cmp_val[1];
         A_CMP0 + 4'd2:   bus_rdata             = cmp_val[2];
         A_CMP0 + 4'd3:   bus_rdata             = cmp_val[3];
         default:         bus_rdata             = '0;
      endcase
   end

   // R1
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (cnt_q == $past(cnt_q) + 1'b1));
   // R9
   shared_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && !det[NUM_EDG-1] && !flag_w[BIT_SHARED] && !(bus_wr && bus_addr == A_MODE))
      |=> !flag_w[BIT_SHARED]);
endmodule

// File: tb/capcmp_timer_test.sv
module capcmp_timer_test;
   import capcmp_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [3:0]   addr = '0;
   logic         wr = 1'b0;
   logic [W-1:0] wdata = '0;
   logic [W-1:0] rdata;
   logic [3:0]   cap = '0;
   logic         irq;
   int           checks = 0;
   int           fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   capcmp_timer #(.CNT_W(W)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (addr),
      .bus_wr    (wr),
      .bus_wdata (wdata),
      .bus_rdata (rdata),
      .cap_in    (cap),
      .irq       (irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // drive from a point in the low phase; returns at the next falling edge
   task automatic bus_wr(input logic [3:0] a, input logic [W-1:0] d);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [3:0] a, output logic [W-1:0] v);
      addr = a;
      #1;
      v = rdata;
   endtask

   task automatic t_reset();
      logic [W-1:0] v;
      bus_rd(A_EDGE, v); chk("R10 edge reg", v, 0);
      bus_rd(A_MASK, v); chk("R10 mask reg", v, 0);
      bus_rd(A_FLAG, v); chk("R10 flag reg", v, 0);
      bus_rd(A_MODE, v); chk("R10 mode reg", v, 0);
      chk("R10 irq", irq, 0);
      @(negedge clk);
      bus_rd(A_CMP0, v); chk("R4 compare reset", v, 8'hFF);
   endtask

   task automatic t_counter();
      logic [W-1:0] a, b;
      @(negedge clk);
      bus_rd(A_CNT, a);
      @(negedge clk);
      bus_rd(A_CNT, b);
      chk("R1 step", b, W'(a + 1));
      for (int k = 0; k < 300; k++) begin
         bus_rd(A_CNT, a);
         if (a == 8'hFF) break;
         @(negedge clk);
      end
      chk("R1 reached max", a, 8'hFF);
      @(negedge clk);
      bus_rd(A_CNT, b);
      chk("R1 wrap", b, 0);
   endtask

   task automatic t_compare(input int i);
      logic [W-1:0] c, v;
      logic [3:0]   a = A_CMP0 + 4'(i);
      @(negedge clk);
      bus_wr(A_FLAG, 8'hFF);
      bus_rd(A_CNT, c);
      bus_wr(a, W'(c + 5));
      bus_rd(a, v); chk("R4 compare readback", v, W'(c + 5));
      repeat (4) @(negedge clk);
      bus_rd(A_FLAG, v); chk("R4 R5 compare flag before match", v[7-i], 0);
      @(negedge clk);
      bus_rd(A_FLAG, v); chk("R4 R5 compare flag after match", v[7-i], 1);
   endtask

   task automatic t_w1c_and_set_wins();
      logic [W-1:0] c, v;
      t_compare(0);
      bus_wr(A_FLAG, 8'h00);
      bus_rd(A_FLAG, v); chk("R6 zero write keeps flag", v[7], 1);
      bus_wr(A_FLAG, 8'h80);
      bus_rd(A_FLAG, v); chk("R6 one write clears flag", v[7], 0);
      // set and clear in the same cycle
      @(negedge clk);
      bus_wr(A_FLAG, 8'hFF);
      bus_rd(A_CNT, c);
      bus_wr(A_CMP0 + 4'd1, W'(c + 4));
      repeat (3) @(negedge clk);
      bus_wr(A_FLAG, 8'h40);
      bus_rd(A_FLAG, v); chk("R7 set beats clear", v[6], 1);
      bus_wr(A_FLAG, 8'h40);
      bus_rd(A_FLAG, v); chk("R6 later clear", v[6], 0);
   endtask

   task automatic t_irq();
      logic [W-1:0] v;
      t_compare(0);
      bus_wr(A_MASK, 8'h00);
      chk("R8 masked flag gives no irq", irq, 0);
      bus_wr(A_MASK, 8'h80);
      chk("R8 enabled flag raises irq", irq, 1);
      bus_wr(A_FLAG, 8'h80);
      chk("R8 irq drops after clear", irq, 0);
      bus_wr(A_MASK, 8'h00);
   endtask

   // ch: 0..2 dedicated, 3 shared; bit position per R5
   task automatic t_edge(input int ch, input logic lvl, input bit hit, input string tag);
      logic [W-1:0] c, v;
      int           fb = (ch == 3) ? 3 : 2 - ch;
      logic [3:0]   ca = (ch == 3) ? A_SHARED : A_CAP0 + 4'(ch);
      @(negedge clk);
      bus_wr(A_FLAG, 8'hFF);
      bus_rd(A_CNT, c);
      cap[ch] = lvl;
      repeat (2) @(negedge clk);
      bus_rd(A_FLAG, v); chk({tag, " no flag before latency"}, v[fb], 0);
      @(negedge clk);
      bus_rd(A_FLAG, v); chk(tag, v[fb], hit);
      if (hit) begin
         bus_rd(ca, v); chk({tag, " R3 captured value"}, v, W'(c + 2));
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic t_edges();
      @(negedge clk);
      bus_wr(A_EDGE, 8'h00);
      t_edge(0, 1, 0, "R2 code 00 ignores rise");
      t_edge(0, 0, 0, "R2 code 00 ignores fall");
      bus_wr(A_EDGE, 8'h40);
      t_edge(0, 1, 0, "R2 field order: shared field does not arm capture 1");
      t_edge(0, 0, 0, "R2 field order fall");
      bus_wr(A_EDGE, 8'h10);
      t_edge(0, 1, 1, "R2 R3 capture1 rise code 01");
      t_edge(0, 0, 0, "R2 capture1 fall ignored code 01");
      bus_wr(A_EDGE, 8'h08);
      t_edge(1, 1, 0, "R2 capture2 rise ignored code 10");
      t_edge(1, 0, 1, "R2 R3 capture2 fall code 10");
      bus_wr(A_EDGE, 8'h03);
      t_edge(2, 1, 1, "R2 R3 capture3 rise code 11");
      t_edge(2, 0, 1, "R2 R3 capture3 fall code 11");
   endtask

   task automatic t_shared();
      logic [W-1:0] c, v;
      // compare mode
      @(negedge clk);
      bus_wr(A_MODE, 8'h00);
      bus_wr(A_EDGE, 8'hC0);
      t_edge(3, 1, 0, "R9 compare mode ignores capture edge");
      bus_wr(A_FLAG, 8'hFF);
      bus_rd(A_CNT, c);
      bus_wr(A_SHARED, W'(c + 5));
      repeat (4) @(negedge clk);
      bus_rd(A_FLAG, v); chk("R9 shared compare before match", v[3], 0);
      @(negedge clk);
      bus_rd(A_FLAG, v); chk("R9 shared compare match", v[3], 1);
      // capture mode: compare must not set the flag
      bus_wr(A_MODE, 8'h01);
      bus_wr(A_EDGE, 8'h00);
      bus_wr(A_FLAG, 8'hFF);
      bus_rd(A_CNT, c);
      bus_wr(A_SHARED, W'(c + 4));
      repeat (5) @(negedge clk);
      bus_rd(A_FLAG, v); chk("R9 capture mode ignores compare", v[3], 0);
      bus_wr(A_EDGE, 8'h80);
      t_edge(3, 0, 1, "R9 R3 shared capture fall code 10");
      bus_wr(A_MODE, 8'h00);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_counter();
      for (int i = 0; i < NUM_OC; i++) t_compare(i);
      t_w1c_and_set_wins();
      t_irq();
      t_edges();
      t_shared();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule